// File: doc/BRIEF.md
# Holdover Frequency Word Memory

This block sits between the loop filter of a digital phase-locked loop and the oscillator that the filter steers. While the loop is locked, the live frequency control word goes straight through to the oscillator control output with one register of delay. At the same time, a periodic 32 ms tick drives a two-slot snapshot history. On each tick, the newest snapshot moves into the older slot and the live word is captured into the newest slot. The older slot therefore always holds a word captured between 32 ms and 64 ms in the past.

When the controlling state machine leaves the locked state for holdover, the history stops updating in that same cycle. The output then freezes at the older snapshot, so any jitter on the reference just before it failed has no influence on the coasting frequency. From that point the loop filter input is ignored. The held word stays constant, so drift of the master oscillator is no longer corrected. A free-running mode forces a zero (nominal) offset.

When the block returns to the locked state, the history restarts. It is not valid again until two fresh ticks have been taken.

Top module: `freq_hold_mem`

## Requirements
- R1: After reset, `freq_out` is zero and `hist_valid` is low.
- R2: The mode encoding is 2'b00 = track, 2'b01 = hold, 2'b10 and 2'b11 = free-run. In the cycle after a track cycle, `freq_out` equals the `freq_in` applied in that track cycle.
- R3: A `tick` in a track cycle moves the newest snapshot into the older slot and captures the `freq_in` of that cycle as the newest snapshot.
- R4: In the cycle after a hold cycle with a valid history, `freq_out` equals the older snapshot. That snapshot is the word captured by the second-to-last tick before hold was entered. It stays constant for as long as hold lasts, whatever `freq_in` does.
- R5: `tick` has no effect on the history in hold or free-run cycles. Snapshot updates stop in the very cycle the mode leaves track.
- R6: `hist_valid` rises in the cycle after the second track tick since reset or restart. A hold cycle while `hist_valid` is low yields a zero `freq_out`.
- R7: In the cycle after a free-run cycle, `freq_out` is zero, whatever the history holds.
- R8: The first track cycle after any non-track cycle clears the tick count, so `hist_valid` drops. A tick in that same cycle counts as the first fresh tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_in | input | FW | Signed live frequency word from the loop filter |
| tick | input | 1 | One-cycle pulse every 32 ms |
| mode | input | 2 | Loop mode: 00 track, 01 hold, 1x free-run |
| freq_out | output | FW | Signed frequency word to the oscillator |
| hist_valid | output | 1 | Two track ticks taken since reset or restart |

## Verification
Several properties are checked on every cycle: pass-through of the live word in track, the zero word in free-run and in hold without history, constancy of the output across consecutive hold cycles, and that validity only ever rises after a track tick. Other behaviour shows only in the bench's scenarios: which snapshot is actually held (the one aged by two ticks, not the latest), that ticks during hold leave the held word untouched after a later return, and that a return to track restarts the count including a tick in the return cycle.

// File: rtl/freq_hold_pkg.sv
package freq_hold_pkg;

    typedef enum logic [1:0] {
        MD_TRACK    = 2'b00,
        MD_HOLD     = 2'b01,
        MD_FREE     = 2'b10,
        MD_FREE_ALT = 2'b11
    } loop_mode_e;

    // number of track ticks needed before the older slot is trustworthy
    localparam int unsigned FILL_TICKS = 2;

    function automatic logic is_track(input loop_mode_e m);
        return m == MD_TRACK;
    endfunction

    function automatic logic is_hold(input loop_mode_e m);
        return m == MD_HOLD;
    endfunction

endpackage

// File: rtl/fhm_history.sv
module fhm_history
    import freq_hold_pkg::*;
#(
    parameter int FW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [FW-1:0] live_word,
    input  logic                 tick,
    input  loop_mode_e           md,
    output logic signed [FW-1:0] aged_word,
    output logic                 ready
);
    localparam int CW = $clog2(FILL_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(FILL_TICKS);

    typedef struct packed {
        logic signed [FW-1:0] newest;
        logic signed [FW-1:0] older;
        logic [CW-1:0]        cnt;
        logic                 was_track;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.was_track = is_track(md);
        if (is_track(md)) begin
            if (!st_q.was_track) begin
                // restart after coasting: old history no longer counts
                st_d.cnt = '0;
            end
            if (tick) begin
                st_d.older  = st_q.newest;
                st_d.newest = live_word;
                if (!st_q.was_track) begin
                    st_d.cnt = CW'(1);
                end else if (st_q.cnt != FULL) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.newest    <= '0;
            st_q.older     <= '0;
            st_q.cnt       <= '0;
            st_q.was_track <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign aged_word = st_q.older;
    assign ready     = (st_q.cnt == FULL);

endmodule

// File: rtl/fhm_select.sv
module fhm_select
    import freq_hold_pkg::*;
#(
    parameter int FW = 24
) (
    input  loop_mode_e           md,
    input  logic signed [FW-1:0] live_word,
    input  logic signed [FW-1:0] aged_word,
    input  logic                 ready,
    output logic signed [FW-1:0] next_word
);
    always_comb begin
        unique case (md)
            MD_TRACK: next_word = live_word;
            MD_HOLD:  next_word = ready ? aged_word : '0;
            default:  next_word = '0;
        endcase
    end
endmodule

// File: rtl/freq_hold_mem.sv
module freq_hold_mem
    import freq_hold_pkg::*;
#(
    parameter int FW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [FW-1:0] freq_in,
    input  logic                 tick,
    input  logic [1:0]           mode,
    output logic signed [FW-1:0] freq_out,
    output logic                 hist_valid
);
    typedef struct packed {
        logic signed [FW-1:0] word;
    } out_t;

    loop_mode_e           md;
    logic signed [FW-1:0] aged_word;
    logic signed [FW-1:0] next_word;
    logic                 ready;
    out_t                 o_d, o_q;

    assign md = loop_mode_e'(mode);

    fhm_history #(.FW(FW)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_word (freq_in),
        .tick      (tick),
        .md        (md),
        .aged_word (aged_word),
        .ready     (ready)
    );

    fhm_select #(.FW(FW)) u_sel (
        .md        (md),
        .live_word (freq_in),
        .aged_word (aged_word),
        .ready     (ready),
        .next_word (next_word)
    );

    always_comb begin
        o_d      = o_q;
        o_d.word = next_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign freq_out   = o_q.word;
    assign hist_valid = ready;

endmodule

// File: rtl/freq_hold_mem_chk.sv
module freq_hold_mem_chk #(
    parameter int FW = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic signed [FW-1:0] freq_in,
    input logic                 tick,
    input logic [1:0]           mode,
    input logic signed [FW-1:0] freq_out,
    input logic                 hist_valid
);
    // R2
    track_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b00) |-> freq_out == $past(freq_in));

    // R7
    free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode[1])) |-> freq_out == '0);

    // R4
    hold_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01 && mode == 2'b01) |=> $stable(freq_out));

    // R6
    hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b01 && !$past(hist_valid)) |-> freq_out == '0);

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(hist_valid)) |-> ($past(tick) && $past(mode) == 2'b00));
endmodule

bind freq_hold_mem freq_hold_mem_chk #(.FW(FW)) u_chk (.*);

// File: tb/sim_freq_hold_mem.sv
module sim_freq_hold_mem;
    localparam int FW = 24;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [FW-1:0] freq_in = '0;
    logic                 tick = 1'b0;
    logic [1:0]           mode = 2'b00;
    logic signed [FW-1:0] freq_out;
    logic                 hist_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic signed [FW-1:0] word;
        logic                 valid;
        string                req;
    } exp_t;

    exp_t sb[$];

    // requirement model state
    logic signed [FW-1:0] m_new = '0, m_old = '0;
    int m_cnt = 0;
    bit m_wtrack = 1'b1;

    always #5 clk = ~clk;

    freq_hold_mem #(.FW(FW)) u0 (.*);

    task automatic check(input string req, input logic signed [FW-1:0] aw, input logic signed [FW-1:0] ew,
                         input logic av, input logic ev);
        n_chk++;
        if (aw !== ew || av !== ev) begin
            n_bad++;
            $display("FAIL %s: freq_out=%0d valid=%0b, expected %0d valid=%0b", req, aw, av, ew, ev);
        end
    endtask

    task automatic step(input logic [1:0] md, input int w, input logic tk, input string req);
        exp_t e;
        @(negedge clk);
        mode = md; freq_in = FW'(w); tick = tk;
        // R2 R4 R6 R7: output word
        if (md == 2'b00)      e.word = FW'(w);
        else if (md == 2'b01) e.word = (m_cnt >= 2) ? m_old : '0;
        else                  e.word = '0;
        // R3 R5 R8: history
        if (md == 2'b00) begin
            if (!m_wtrack) m_cnt = 0;
            if (tk) begin
                m_old = m_new; m_new = FW'(w);
                if (m_cnt < 2) m_cnt++;
            end
        end
        m_wtrack = (md == 2'b00);
        e.valid = (m_cnt >= 2);
        e.req = req;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, freq_out, e.word, hist_valid, e.valid);
        end
    end

    initial begin
        #200_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", freq_out, '0, hist_valid, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        step(2'b00, 1000, 1'b0, "R2");
        step(2'b00, -250, 1'b0, "R2");
        step(2'b00, 77, 1'b1, "R3 first tick");
        step(2'b01, 9999, 1'b0, "R6 hold before valid");
        step(2'b00, 500, 1'b0, "R8 restart");
        step(2'b00, 321, 1'b1, "R3");
        step(2'b00, -40, 1'b0, "R2");
        step(2'b00, 654, 1'b1, "R6 second tick");
        step(2'b00, 888, 1'b0, "R2");
        step(2'b00, -900, 1'b0, "R2 jitter before loss");
        step(2'b01, 5555, 1'b1, "R4 hold entry aged word");
        for (int i = 0; i < 4; i++) step(2'b01, i * 1111 - 3000, 1'b1, "R5 R4 hold ignores input");
        step(2'b10, 4242, 1'b1, "R7 freerun");
        step(2'b11, -4242, 1'b0, "R7 freerun alt");
        step(2'b01, 1, 1'b0, "R5 history kept");
        step(2'b00, 700, 1'b1, "R8 tick at restart");
        step(2'b01, 2, 1'b0, "R8 hold after one fresh tick");
        step(2'b00, 800, 1'b1, "R8 restart again");
        step(2'b00, 900, 1'b1, "R6 valid again");
        step(2'b01, 0, 1'b0, "R4 held aged word");
        step(2'b01, 0, 1'b0, "R4");
        step(2'b00, -1, 1'b0, "R2");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule